// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM that stores 16-bit words. A host drives a select line, a serial clock and a serial data input, and reads a serial data output. All three host lines are brought into the system clock domain by synchronizer flops. Edges of the serial clock are then found by comparing the synchronized level with its value one system clock earlier. The word array holds 64 or 256 words, set by the address-width parameter (6 or 8). Every word is a register that reset leaves fully erased.

A command is a start bit, a two-bit opcode, an address and, for the two write forms, 16 data bits. Opcode 00 does not name one command. The two most significant address bits choose one of four housekeeping operations, and the lower address bits are ignored. A programming operation does not start when its last bit arrives. It starts when select falls after the command and then runs for a fixed number of system clocks. While it runs, raising select shows its progress on the data output.

Top module: `sep_eeprom`

## Requirements
- R1: After reset every word reads 0xFFFF, programming is disabled and data-out is 0.
- R2: While select is high, zeros clocked in before the first 1 are ignored. The first 1 is the start bit. It is followed by a two-bit opcode and ADDR_W address bits, each sampled on a rising serial clock edge, most significant bit first.
- R3: Opcode 10 reads. After the last address bit, data-out shows a single 0. Each of the next 16 rising serial clock edges then presents the next bit of the addressed word, bit 15 first. The 17th edge returns data-out to 0.
- R4: Opcode 01 writes. It takes 16 data bits, most significant first, after the address, and stores them in the addressed word.
- R5: Opcode 11 erases the addressed word to 0xFFFF.
- R6: In opcode 00, address bits [ADDR_W-1:ADDR_W-2] choose the operation: 11 enables programming, 00 disables it, 10 erases every word to 0xFFFF, and 01 takes 16 data bits and writes them to every word.
- R7: Write, erase, erase-all and write-all leave the memory unchanged while programming is disabled. After such an ignored command, data-out does not show a ready indication.
- R8: A programming command starts when select falls after it and lasts PROG_CYCLES system clocks. With select high, data-out reads 0 while the operation runs and 1 once it is done. The 1 stays until select falls.
- R9: Dropping select before a command is complete abandons it. The memory is unchanged and the next start bit is decoded normally.
- R10: Data-out is 0 whenever the synchronized select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select from the host, active high |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data into the device |
| sdo_o | output | 1 | Serial data out of the device (read data and busy/ready status) |

## Verification
A decoder left in the wrong state shows up on the next read. The data-out stream loses its leading 0, or its 16 bits are offset by one or more positions. Either fault is visible within 17 serial clocks of the last address bit. A wrong enable flag or a wrongly chosen housekeeping operation stays hidden until the next read of an affected word. That is why the bench reads words back right after every programming command, and also reads words the command should not have touched. Busy-timer errors appear as a ready indication at the wrong cycle, measured from the falling edge of select.

// File: rtl/sep_pkg.sv
package sep_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPC,
        S_ADR,
        S_DAT,
        S_RD,
        S_HOLD,
        S_ARM,
        S_PROG
    } sep_state_e;

    // two-bit command field
    localparam logic [1:0] OP_EXT = 2'b00;
    localparam logic [1:0] OP_WR  = 2'b01;
    localparam logic [1:0] OP_RD  = 2'b10;
    localparam logic [1:0] OP_ER  = 2'b11;

    // sub-commands of OP_EXT, taken from the top two address bits
    localparam logic [1:0] X_DIS   = 2'b00;
    localparam logic [1:0] X_WRALL = 2'b01;
    localparam logic [1:0] X_ERALL = 2'b10;
    localparam logic [1:0] X_EN    = 2'b11;

endpackage

// File: rtl/sep_sync.sv
module sep_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign lvl_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sep_array.sv
module sep_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          wall_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic          hit;
        logic [DW-1:0] word_d;

        always_comb begin
            hit    = wall_i || (we_i && (waddr_i == AW'(g)));
            word_d = hit ? wdata_i : mem_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '1;
            else        mem_q[g] <= word_d;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sep_ptimer.sv
module sep_ptimer #(
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CW = $clog2(PROG_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)             cnt_d = CW'(PROG_CYCLES);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
    assign done_o = (cnt_q == CW'(1));
endmodule

// File: rtl/sep_ctrl.sv
module sep_ctrl
    import sep_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_i,
    input  logic          sck_i,
    input  logic          sdi_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    input  logic          tmr_done_i,
    output logic          tmr_start_o,
    output logic          mem_we_o,
    output logic          mem_wall_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          prog_en_o,
    output logic          sdo_o
);
    localparam int CW = $clog2(DW + 2);

    typedef struct packed {
        sep_state_e    st;
        logic [CW-1:0] cnt;
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] sh;
        logic          en;
        logic          rdy;
        logic          sdo;
        logic          pall;
        logic          sck_p;
        logic          sel_p;
    } ctl_t;

    ctl_t q, n;
    logic sck_rise, sel_fall;

    assign sck_rise  = sck_i && !q.sck_p;
    assign sel_fall  = !sel_i && q.sel_p;
    assign rd_addr_o = {q.addr[AW-2:0], sdi_i};

    always_comb begin
        n           = q;
        n.sck_p     = sck_i;
        n.sel_p     = sel_i;
        tmr_start_o = 1'b0;
        mem_we_o    = 1'b0;
        mem_wall_o  = 1'b0;

        if (q.st == S_PROG) begin
            // host lines are ignored until the operation completes
            if (tmr_done_i) begin
                mem_we_o   = !q.pall;
                mem_wall_o = q.pall;
                n.st       = S_IDLE;
                n.rdy      = 1'b1;
            end
        end else if (!sel_i) begin
            if (q.st == S_ARM && sel_fall) begin
                tmr_start_o = 1'b1;
                n.st        = S_PROG;
            end else begin
                n.st = S_IDLE;
            end
            if (sel_fall) n.rdy = 1'b0;
        end else if (sck_rise) begin
            unique case (q.st)
                S_IDLE: begin
                    if (sdi_i) begin
                        n.st  = S_OPC;
                        n.cnt = '0;
                        n.rdy = 1'b0;
                    end
                end
                S_OPC: begin
                    n.op  = {q.op[0], sdi_i};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CW'(1)) begin
                        n.st  = S_ADR;
                        n.cnt = '0;
                    end
                end
                S_ADR: begin
                    n.addr = rd_addr_o;
                    n.cnt  = q.cnt + 1'b1;
                    if (q.cnt == CW'(AW - 1)) begin
                        n.cnt = '0;
                        unique case (q.op)
                            OP_RD: begin
                                n.sh  = rd_data_i;
                                n.sdo = 1'b0;
                                n.st  = S_RD;
                            end
                            OP_WR: begin
                                n.pall = 1'b0;
                                n.st   = S_DAT;
                            end
                            OP_ER: begin
                                n.sh   = '1;
                                n.pall = 1'b0;
                                n.st   = q.en ? S_ARM : S_HOLD;
                            end
                            default: begin
                                unique case (rd_addr_o[AW-1 -: 2])
                                    X_EN: begin
                                        n.en = 1'b1;
                                        n.st = S_HOLD;
                                    end
                                    X_DIS: begin
                                        n.en = 1'b0;
                                        n.st = S_HOLD;
                                    end
                                    X_ERALL: begin
                                        n.sh   = '1;
                                        n.pall = 1'b1;
                                        n.st   = q.en ? S_ARM : S_HOLD;
                                    end
                                    default: begin
                                        n.pall = 1'b1;
                                        n.st   = S_DAT;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                S_DAT: begin
                    n.sh  = {q.sh[DW-2:0], sdi_i};
                    n.cnt = q.cnt + 1'b1;
                    if (q.cnt == CW'(DW - 1)) begin
                        n.st = q.en ? S_ARM : S_HOLD;
                    end
                end
                S_RD: begin
                    if (q.cnt == CW'(DW)) begin
                        n.sdo = 1'b0;
                        n.st  = S_HOLD;
                    end else begin
                        n.sdo = q.sh[DW-1];
                        n.sh  = {q.sh[DW-2:0], 1'b0};
                        n.cnt = q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (n.st == S_IDLE)    n.sdo = sel_i && n.rdy;
        else if (n.st != S_RD) n.sdo = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign wr_addr_o = q.addr;
    assign wr_data_o = q.sh;
    assign prog_en_o = q.en;
    assign sdo_o     = q.sdo;
endmodule

// File: rtl/sep_eeprom.sv
module sep_eeprom #(
    parameter int ADDR_W      = 6,
    parameter int WORD_W      = 16,
    parameter int PROG_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic sck_i,
    input  logic sdi_i,
    output logic sdo_o
);
    logic [2:0]        lvl;
    logic              sel_s, sck_s, sdi_s;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [WORD_W-1:0] rd_data, wr_data;
    logic              mem_we, mem_wall, prog_en;
    logic              tmr_start, tmr_busy, tmr_done;

    sep_sync #(.W(3), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sel_i, sck_i, sdi_i}),
        .lvl_o   (lvl)
    );

    assign sel_s = lvl[2];
    assign sck_s = lvl[1];
    assign sdi_s = lvl[0];

    sep_ctrl #(.AW(ADDR_W), .DW(WORD_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (sel_s),
        .sck_i       (sck_s),
        .sdi_i       (sdi_s),
        .rd_data_i   (rd_data),
        .rd_addr_o   (rd_addr),
        .tmr_done_i  (tmr_done),
        .tmr_start_o (tmr_start),
        .mem_we_o    (mem_we),
        .mem_wall_o  (mem_wall),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .prog_en_o   (prog_en),
        .sdo_o       (sdo_o)
    );

    sep_array #(.AW(ADDR_W), .DW(WORD_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .wall_i  (mem_wall),
        .waddr_i (wr_addr),
        .wdata_i (wr_data),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    sep_ptimer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .busy_o  (tmr_busy),
        .done_o  (tmr_done)
    );
endmodule

// File: rtl/sep_eeprom_chk.sv
module sep_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_s,
    input logic sdo_o,
    input logic tmr_busy,
    input logic tmr_done,
    input logic mem_we,
    input logic mem_wall,
    input logic prog_en
);
    // R10: output quiet while deselected
    a_r10_quiet_when_deselected: assert property (
        @(posedge clk) disable iff (!rst_n) !sel_s |=> !sdo_o);

    // R7: memory changes only while programming is enabled
    a_r7_commit_needs_enable: assert property (
        @(posedge clk) disable iff (!rst_n) (mem_we || mem_wall) |-> prog_en);

    // R8: memory changes only at the end of the programming interval
    a_r8_commit_at_end: assert property (
        @(posedge clk) disable iff (!rst_n) (mem_we || mem_wall) |-> tmr_done);

    // R8: busy shows as 0 on data-out
    a_r8_busy_reads_zero: assert property (
        @(posedge clk) disable iff (!rst_n) (tmr_busy && !tmr_done) |=> !sdo_o);

    // R6: enable flag cannot change while an operation runs
    a_r6_enable_stable_busy: assert property (
        @(posedge clk) disable iff (!rst_n) tmr_busy |=> $stable(prog_en));
endmodule

bind sep_eeprom sep_eeprom_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_s    (sel_s),
    .sdo_o    (sdo_o),
    .tmr_busy (tmr_busy),
    .tmr_done (tmr_done),
    .mem_we   (mem_we),
    .mem_wall (mem_wall),
    .prog_en  (prog_en)
);

// File: tb/sep_eeprom_test.sv
module sep_eeprom_test;
    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;
    localparam int PC    = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0, sck = 1'b0, sdi = 1'b0;
    logic sdo;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] ref_mem [WORDS];
    logic        ref_en;

    always #5 clk = ~clk;

    sep_eeprom #(.ADDR_W(AW), .WORD_W(16), .PROG_CYCLES(PC)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (sel),
        .sck_i (sck),
        .sdi_i (sdi),
        .sdo_o (sdo)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sdi = b;
        wclk(4);
        sck = 1'b1;
        wclk(8);
        sck = 1'b0;
        wclk(4);
    endtask

    task automatic select_on();
        @(negedge clk);
        sel = 1'b1;
        wclk(6);
    endtask

    task automatic select_off();
        @(negedge clk);
        sel = 1'b0;
        sdi = 1'b0;
        wclk(8);
        chk("R10 deselected", 32'(sdo), 32'd0);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [AW-1:0] a);
        bit_out(1'b1);
        bit_out(op[1]);
        bit_out(op[0]);
        for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) bit_out(d[i]);
    endtask

    // ends a command by dropping select and watches the status on data-out
    task automatic prog_finish(input logic expect_prog);
        int  cnt;
        logic seen;
        @(negedge clk);
        sel = 1'b0;
        sdi = 1'b0;
        cnt = 0;
        repeat (3) begin @(negedge clk); cnt++; end
        sel = 1'b1;
        repeat (7) begin @(negedge clk); cnt++; end
        chk(expect_prog ? "R8 busy shows 0" : "R7 no status", 32'(sdo), 32'd0);
        seen = 1'b0;
        while (cnt < PC + 40 && !seen) begin
            @(negedge clk);
            cnt++;
            if (sdo === 1'b1) seen = 1'b1;
        end
        if (expect_prog) begin
            chk("R8 ready shows 1", 32'(seen), 32'd1);
            chk("R8 ready latency", 32'(cnt >= PC && cnt <= PC + 10), 32'd1);
        end else begin
            chk("R7 ignored command never ready", 32'(seen), 32'd0);
        end
        select_off();
    endtask

    task automatic do_read(input logic [AW-1:0] a, input int lead, input string tag);
        logic [15:0] v;
        select_on();
        for (int i = 0; i < lead; i++) bit_out(1'b0);
        send_hdr(2'b10, a);
        chk("R3 dummy zero", 32'(sdo), 32'd0);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            bit_out(1'b0);
            v = {v[14:0], sdo};
        end
        chk(tag, 32'(v), 32'(ref_mem[a]));
        bit_out(1'b0);
        chk("R3 zero after last bit", 32'(sdo), 32'd0);
        select_off();
    endtask

    task automatic cmd_ext(input logic [1:0] sub);
        select_on();
        send_hdr(2'b00, {sub, {(AW - 2){1'b0}}});
        select_off();
        if (sub == 2'b11) ref_en = 1'b1;
        if (sub == 2'b00) ref_en = 1'b0;
    endtask

    task automatic cmd_write(input logic [AW-1:0] a, input logic [15:0] d);
        select_on();
        send_hdr(2'b01, a);
        send_word(d);
        if (ref_en) ref_mem[a] = d;
        prog_finish(ref_en);
    endtask

    task automatic cmd_erase(input logic [AW-1:0] a);
        select_on();
        send_hdr(2'b11, a);
        if (ref_en) ref_mem[a] = 16'hFFFF;
        prog_finish(ref_en);
    endtask

    task automatic cmd_wral(input logic [15:0] d);
        select_on();
        send_hdr(2'b00, {2'b01, {(AW - 2){1'b0}}});
        send_word(d);
        if (ref_en) for (int i = 0; i < WORDS; i++) ref_mem[i] = d;
        prog_finish(ref_en);
    endtask

    task automatic cmd_eral();
        select_on();
        send_hdr(2'b00, {2'b10, {(AW - 2){1'b0}}});
        if (ref_en) for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hFFFF;
        prog_finish(ref_en);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd20250);
        for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hFFFF;
        ref_en = 1'b0;

        wclk(5);
        chk("R1 data-out in reset", 32'(sdo), 32'd0);
        rst_n = 1'b1;
        wclk(5);
        chk("R1 data-out after reset", 32'(sdo), 32'd0);

        do_read(6'd0, 0, "R1 erased word 0");
        do_read(6'd63, 0, "R1 erased word 63");

        // R7: programming disabled after reset
        cmd_write(6'd5, 16'h1234);
        do_read(6'd5, 0, "R7 write ignored while disabled");

        cmd_ext(2'b11);
        cmd_write(6'd5, 16'hA5C3);
        do_read(6'd5, 0, "R4 written word");
        do_read(6'd5, 3, "R2 leading zeros ignored");

        cmd_write(6'd6, 16'h0001);
        cmd_erase(6'd5);
        do_read(6'd5, 0, "R5 erased word");
        do_read(6'd6, 0, "R5 neighbour untouched");

        cmd_wral(16'h3C96);
        do_read(6'd0, 0, "R6 write-all word 0");
        do_read(6'd17, 0, "R6 write-all word 17");
        do_read(6'd63, 0, "R6 write-all word 63");

        cmd_eral();
        do_read(6'd9, 0, "R6 erase-all word 9");

        // R9: abort a write in the middle of its data
        select_on();
        send_hdr(2'b01, 6'd7);
        for (int i = 0; i < 7; i++) bit_out(1'b0);
        select_off();
        select_on();
        wclk(10);
        chk("R9 aborted write shows no status", 32'(sdo), 32'd0);
        select_off();
        do_read(6'd7, 0, "R9 aborted write left word");
        cmd_write(6'd7, 16'h7E57);
        do_read(6'd7, 0, "R9 next command decoded");

        // random mix against the reference model
        for (int it = 0; it < 40; it++) begin
            logic [AW-1:0] a;
            logic [15:0]   d;
            int unsigned   k;
            k = $urandom % 8;
            a = AW'($urandom);
            d = 16'($urandom);
            if (k < 3)       do_read(a, int'($urandom % 3), "R4 random read");
            else if (k < 6)  cmd_write(a, d);
            else if (k == 6) cmd_erase(a);
            else             cmd_ext(ref_en ? 2'b00 : 2'b11);
        end

        cmd_ext(2'b11);
        cmd_write(6'd3, 16'h0F0F);
        cmd_ext(2'b00);
        cmd_write(6'd3, 16'hBEEF);
        do_read(6'd3, 0, "R7 write ignored after disable");
        cmd_erase(6'd3);
        do_read(6'd3, 0, "R7 erase ignored after disable");
        cmd_eral();
        do_read(6'd3, 0, "R7 erase-all ignored after disable");

        summary();
        $finish;
    end
endmodule